// File: doc/BRIEF.md
# Dual Alarm Interrupt Controller

This block watches the current time of a real-time clock and raises interrupts when it reaches programmed alarm settings. There are two alarm channels. The first compares seconds, minutes, hours and a day/date field. The second has no seconds setting and is checked only on the first second of a minute. The comparison runs only in the cycle that carries the once-per-second time update strobe. A hit moves that channel's flag state machine from `FLG_IDLE` to `FLG_PENDING` (transition MATCH). The flag stays there until the host clears it (transition ACK, `FLG_PENDING` to `FLG_IDLE`).

Each flag is gated by its own enable. A routing control maps the gated flags onto two active-low open-drain pins, which are modelled as pull-low enables. The second pin either carries the second alarm or a square wave. The square wave is divided down from a strobe that fires at 65,536 pulses per second, which is every half period of a 32.768 kHz reference. The time and register values come in as plain inputs. Computing the time is done elsewhere.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: In a cycle with `sec_tick`=1, alarm 1 sets its flag when every unmasked field matches. Seconds, minutes and hours compare bits 6:0 of the alarm byte to the full time byte. The hours byte includes its 12/24 and AM/PM bits.
- R2: Bit 7 of any alarm byte is a mask. When it is 1, that field counts as matching whatever the time holds.
- R3: In a day/date byte, bit 6 selects the compare target: 1 compares bits 5:0 with `tm_wday`, 0 compares bits 5:0 with `tm_mday`.
- R4: Alarm 2 compares minutes, hours and day/date like alarm 1. It can only set its flag on a tick where `tm_sec` is 8'h00.
- R5: A matching time in a cycle without `sec_tick` leaves both flags unchanged.
- R6: A set flag stays 1 until its clear strobe (`al1_clr`/`al2_clr`) is high at a clock edge. The flag then reads 0 and its pin is released right after that edge.
- R7: If a set event and a clear strobe for the same channel meet at one edge, the flag ends at 1.
- R8: With `route_split`=1, `pin0_pull_lo` = `al1_flag`&`al1_en` and `pin1_pull_lo` = `al2_flag`&`al2_en`.
- R9: With `route_split`=0, `pin0_pull_lo` is high when either enabled flag is set, and `pin1_pull_lo` carries the square wave. The pin is pulled low while the wave is low.
- R10: A 16-bit divider counts `half_tick` strobes. The wave is the inverse of one counter bit, chosen by `sq_rate`: 2'b11 uses bit 0 (32.768 kHz), 2'b10 uses bit 2 (8.192 kHz), 2'b01 uses bit 3 (4.096 kHz), 2'b00 uses bit 15 (1 Hz). After reset the wave first goes low after 1, 4, 8 and 32768 strobes respectively.
- R11: Reset clears both flags and the divider. With `route_split`=1 both pins are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Once-per-second time update strobe |
| half_tick | input | 1 | 65,536 Hz divider strobe |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours with format bits |
| tm_wday | input | 8 | Current weekday |
| tm_mday | input | 8 | Current date of month, BCD |
| al1_sec | input | 8 | Alarm 1 seconds, bit 7 mask |
| al1_min | input | 8 | Alarm 1 minutes, bit 7 mask |
| al1_hour | input | 8 | Alarm 1 hours, bit 7 mask |
| al1_day | input | 8 | Alarm 1 day/date, bit 7 mask, bit 6 select |
| al2_min | input | 8 | Alarm 2 minutes, bit 7 mask |
| al2_hour | input | 8 | Alarm 2 hours, bit 7 mask |
| al2_day | input | 8 | Alarm 2 day/date, bit 7 mask, bit 6 select |
| route_split | input | 1 | 1: separate pins; 0: shared pin plus square wave |
| al1_en | input | 1 | Alarm 1 interrupt enable |
| al2_en | input | 1 | Alarm 2 interrupt enable |
| sq_rate | input | 2 | Square-wave rate code |
| al1_clr | input | 1 | Clear strobe for flag 1 |
| al2_clr | input | 1 | Clear strobe for flag 2 |
| al1_flag | output | 1 | Alarm 1 flag |
| al2_flag | output | 1 | Alarm 2 flag |
| pin0_pull_lo | output | 1 | Drive-low enable, interrupt pin 0 |
| pin1_pull_lo | output | 1 | Drive-low enable, interrupt/square-wave pin 1 |

## Verification
The bench presents a fully matching time with no tick present. A design that compared every cycle would set the flag early there. It puts alarm 2 on a matching minute at a nonzero second, where a design without the implicit seconds check would fire once per second. It raises a clear in the same cycle as a new match, where a clear-priority design would lose the event. It also measures the cycles to the first falling wave edge for every rate code, where a wrong divider tap would show up as the wrong count. Random runs mix masks, day/date selection, routing and enables against a bench model.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

    localparam int NUM_ALARMS = 2;

    typedef enum logic [0:0] {
        FLG_IDLE    = 1'b0,
        FLG_PENDING = 1'b1
    } flag_state_e;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] wday;
        logic [7:0] mday;
    } tod_t;

    // bit 7 of the setting waives the field; bits 6:0 hold the value
    function automatic logic field_hit(input logic [7:0] setting, input logic [7:0] now_val);
        return setting[7] | ({1'b0, setting[6:0]} == now_val);
    endfunction

    // bit 6 picks weekday (1) or date (0); bits 5:0 hold the value
    function automatic logic day_hit(input logic [7:0] setting,
                                     input logic [7:0] wday,
                                     input logic [7:0] mday);
        logic [7:0] target;
        target = setting[6] ? wday : mday;
        return setting[7] | ({2'b00, setting[5:0]} == target);
    endfunction

endpackage

// File: rtl/alarm_matcher.sv
module alarm_matcher
    import alarm_irq_pkg::*;
(
    input  tod_t       now,
    input  logic [7:0] a_sec,
    input  logic [7:0] a_min,
    input  logic [7:0] a_hour,
    input  logic [7:0] a_day,
    output logic       hit
);

    logic sec_ok;
    logic min_ok;
    logic hour_ok;
    logic day_ok;

    always_comb begin
        sec_ok  = field_hit(a_sec, now.sec);
        min_ok  = field_hit(a_min, now.min);
        hour_ok = field_hit(a_hour, now.hour);
        day_ok  = day_hit(a_day, now.wday, now.mday);
        hit     = sec_ok & min_ok & hour_ok & day_ok;
    end

endmodule

// File: rtl/alarm_flag_fsm.sv
module alarm_flag_fsm
    import alarm_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE:    if (set_evt) state_d = FLG_PENDING;              // MATCH
            FLG_PENDING: if (clr_req && !set_evt) state_d = FLG_IDLE;     // ACK
            default:     state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLG_PENDING);
    end

    // R6: a pending flag survives any edge without a clear
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag);

    // R6: a clear with no competing match drops the flag
    p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && clr_req && !set_evt) |=> !flag);

    // R7: a match always leaves the flag set, clear or not
    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_tick,
    input  logic [1:0] rate,
    output logic       wave
);

    localparam int TAP_FAST = 0;
    localparam int TAP_8K   = 2;
    localparam int TAP_4K   = 3;
    localparam int TAP_SLOW = DIV_W - 1;

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (half_tick) cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        unique case (rate)
            2'b00: wave = ~cnt_q[TAP_SLOW];
            2'b01: wave = ~cnt_q[TAP_4K];
            2'b10: wave = ~cnt_q[TAP_8K];
            2'b11: wave = ~cnt_q[TAP_FAST];
            default: wave = 1'b1;
        endcase
    end

    // R10: the divider only moves on a strobe
    p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !half_tick |=> $stable(cnt_q));

    // R10: each strobe advances the divider by exactly one
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
    import alarm_irq_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick,
    input  logic       half_tick,
    input  logic [7:0] tm_sec,
    input  logic [7:0] tm_min,
    input  logic [7:0] tm_hour,
    input  logic [7:0] tm_wday,
    input  logic [7:0] tm_mday,
    input  logic [7:0] al1_sec,
    input  logic [7:0] al1_min,
    input  logic [7:0] al1_hour,
    input  logic [7:0] al1_day,
    input  logic [7:0] al2_min,
    input  logic [7:0] al2_hour,
    input  logic [7:0] al2_day,
    input  logic       route_split,
    input  logic       al1_en,
    input  logic       al2_en,
    input  logic [1:0] sq_rate,
    input  logic       al1_clr,
    input  logic       al2_clr,
    output logic       al1_flag,
    output logic       al2_flag,
    output logic       pin0_pull_lo,
    output logic       pin1_pull_lo
);

    tod_t now;
    logic [7:0] cfg_sec  [NUM_ALARMS];
    logic [7:0] cfg_min  [NUM_ALARMS];
    logic [7:0] cfg_hour [NUM_ALARMS];
    logic [7:0] cfg_day  [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] hit;
    logic [NUM_ALARMS-1:0] set_evt;
    logic [NUM_ALARMS-1:0] clr_req;
    logic [NUM_ALARMS-1:0] flag;
    logic [NUM_ALARMS-1:0] en;
    logic [NUM_ALARMS-1:0] pend;
    logic wave;

    always_comb begin
        now = '{sec: tm_sec, min: tm_min, hour: tm_hour, wday: tm_wday, mday: tm_mday};
        // alarm 2 has no seconds setting: an unmasked 00 pins it to second zero
        cfg_sec[0]  = al1_sec;
        cfg_sec[1]  = 8'h00;
        cfg_min[0]  = al1_min;
        cfg_min[1]  = al2_min;
        cfg_hour[0] = al1_hour;
        cfg_hour[1] = al2_hour;
        cfg_day[0]  = al1_day;
        cfg_day[1]  = al2_day;
        clr_req     = {al2_clr, al1_clr};
        en          = {al2_en, al1_en};
    end

    for (genvar g = 0; g < NUM_ALARMS; g++) begin : g_alarm
        alarm_matcher u_match (
            .now    (now),
            .a_sec  (cfg_sec[g]),
            .a_min  (cfg_min[g]),
            .a_hour (cfg_hour[g]),
            .a_day  (cfg_day[g]),
            .hit    (hit[g])
        );

        assign set_evt[g] = sec_tick & hit[g];

        alarm_flag_fsm u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (set_evt[g]),
            .clr_req (clr_req[g]),
            .flag    (flag[g])
        );
    end

    sqw_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_tick (half_tick),
        .rate      (sq_rate),
        .wave      (wave)
    );

    always_comb begin
        pend     = flag & en;
        al1_flag = flag[0];
        al2_flag = flag[1];
        unique case (route_split)
            1'b1: begin
                pin0_pull_lo = pend[0];
                pin1_pull_lo = pend[1];
            end
            1'b0: begin
                pin0_pull_lo = |pend;
                pin1_pull_lo = ~wave;
            end
            default: begin
                pin0_pull_lo = 1'b0;
                pin1_pull_lo = 1'b0;
            end
        endcase
    end

    // R5: a flag can only rise after a cycle that carried the update strobe
    p_rise_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al1_flag) || $rose(al2_flag) |-> $past(sec_tick));

    // R4: alarm 2 only rises on second zero
    p_a2_zero_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al2_flag) |-> ($past(tm_sec) == 8'h00));

    // R8: interrupt pin 0 is never pulled without a pending flag behind it
    p_pin0_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pin0_pull_lo |-> (al1_flag || al2_flag));

    // R8: in split routing pin 1 belongs to alarm 2 alone
    p_pin1_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (route_split && pin1_pull_lo) |-> (al2_flag && al2_en));

endmodule

// File: tb/alarm_irq_ctrl_bench.sv
module alarm_irq_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n, sec_tick, half_tick;
    logic [7:0] tm_sec, tm_min, tm_hour, tm_wday, tm_mday;
    logic [7:0] al1_sec, al1_min, al1_hour, al1_day;
    logic [7:0] al2_min, al2_hour, al2_day;
    logic route_split, al1_en, al2_en;
    logic [1:0] sq_rate;
    logic al1_clr, al2_clr;
    logic al1_flag, al2_flag, pin0_pull_lo, pin1_pull_lo;

    int n_cmp = 0;
    int n_bad = 0;
    logic m_f1, m_f2;
    logic [15:0] m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    alarm_irq_ctrl u_alarm_irq_ctrl (.*);

    function automatic logic mdl_field(logic [7:0] a, logic [7:0] t);
        if (a[7]) return 1'b1;
        return a[6:0] == t[6:0] && t[7] == 1'b0;
    endfunction

    function automatic logic mdl_day(logic [7:0] a, logic [7:0] wd, logic [7:0] md);
        if (a[7]) return 1'b1;
        if (a[6]) return (wd[7:6] == 2'b00) && (wd[5:0] == a[5:0]);
        return (md[7:6] == 2'b00) && (md[5:0] == a[5:0]);
    endfunction

    function automatic logic mdl_sq_low(logic [15:0] c, logic [1:0] r);
        case (r)
            2'b11:   return c[0];
            2'b10:   return c[2];
            2'b01:   return c[3];
            default: return c[15];
        endcase
    endfunction

    task automatic expect_bit(string tag, logic act, logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: update the model from the applied inputs, then compare
    task automatic step();
        logic h1, h2;
        @(posedge clk);
        if (!rst_n) begin
            m_f1 = 1'b0; m_f2 = 1'b0; m_cnt = '0;
        end else begin
            h1 = sec_tick && mdl_field(al1_sec, tm_sec) && mdl_field(al1_min, tm_min)
                 && mdl_field(al1_hour, tm_hour) && mdl_day(al1_day, tm_wday, tm_mday);
            h2 = sec_tick && (tm_sec == 8'h00) && mdl_field(al2_min, tm_min)
                 && mdl_field(al2_hour, tm_hour) && mdl_day(al2_day, tm_wday, tm_mday);
            if (h1) m_f1 = 1'b1; else if (al1_clr) m_f1 = 1'b0;
            if (h2) m_f2 = 1'b1; else if (al2_clr) m_f2 = 1'b0;
            if (half_tick) m_cnt = m_cnt + 16'd1;
        end
        #2;
        expect_bit("R1 R2 R3 R5 R6 R7 al1_flag", al1_flag, m_f1);
        expect_bit("R4 R5 R6 R7 al2_flag", al2_flag, m_f2);
        expect_bit("R8 R9 pin0_pull_lo", pin0_pull_lo,
                   route_split ? (m_f1 & al1_en) : ((m_f1 & al1_en) | (m_f2 & al2_en)));
        expect_bit("R8 R9 R10 pin1_pull_lo", pin1_pull_lo,
                   route_split ? (m_f2 & al2_en) : mdl_sq_low(m_cnt, sq_rate));
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] mi, logic [7:0] h,
                            logic [7:0] wd, logic [7:0] md);
        tm_sec = s; tm_min = mi; tm_hour = h; tm_wday = wd; tm_mday = md;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    function automatic logic [7:0] pick(logic [7:0] a, logic [7:0] b);
        return ($urandom % 2) ? a : b;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; sec_tick = 0; half_tick = 0; al1_clr = 0; al2_clr = 0;
        route_split = 1; al1_en = 1; al2_en = 1; sq_rate = 2'b11;
        set_time(8'h15, 8'h30, 8'h08, 8'h03, 8'h12);
        al1_sec = 8'h15; al1_min = 8'h30; al1_hour = 8'h08; al1_day = 8'h12;
        al2_min = 8'h30; al2_hour = 8'h08; al2_day = 8'h12;
        m_f1 = 0; m_f2 = 0; m_cnt = '0;

        // R11: reset state
        do_reset();
        expect_bit("R11 flag1 after reset", al1_flag, 1'b0);
        expect_bit("R11 flag2 after reset", al2_flag, 1'b0);
        expect_bit("R11 pin0 released", pin0_pull_lo, 1'b0);
        expect_bit("R11 pin1 released", pin1_pull_lo, 1'b0);

        // R5: full match but no tick
        step();
        expect_bit("R5 no tick no flag", al1_flag, 1'b0);
        // R1: full match with tick
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R1 exact match", al1_flag, 1'b1);
        expect_bit("R8 pin0 pulled", pin0_pull_lo, 1'b1);
        set_time(8'h16, 8'h30, 8'h08, 8'h03, 8'h12);
        step(); step();
        expect_bit("R6 flag held", al1_flag, 1'b1);
        al1_clr = 1; step(); al1_clr = 0;
        expect_bit("R6 flag cleared", al1_flag, 1'b0);
        expect_bit("R6 pin0 released", pin0_pull_lo, 1'b0);

        // R1: minute mismatch
        set_time(8'h15, 8'h31, 8'h08, 8'h03, 8'h12);
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R1 minute mismatch", al1_flag, 1'b0);
        // R2: mask the minute
        al1_min = 8'h80;
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R2 masked minute", al1_flag, 1'b1);
        al1_clr = 1; step(); al1_clr = 0;
        al1_min = 8'h30;

        // R3: weekday selection vs date selection
        al1_day = 8'h43;
        set_time(8'h15, 8'h30, 8'h08, 8'h03, 8'h05);
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R3 weekday match", al1_flag, 1'b1);
        al1_clr = 1; step(); al1_clr = 0;
        al1_day = 8'h03;
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R3 date compare ignores weekday", al1_flag, 1'b0);

        // R4: alarm 2 needs second zero
        set_time(8'h15, 8'h30, 8'h08, 8'h03, 8'h12);
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R4 nonzero second", al2_flag, 1'b0);
        tm_sec = 8'h00;
        sec_tick = 1; step(); sec_tick = 0;
        expect_bit("R4 second zero", al2_flag, 1'b1);
        expect_bit("R8 pin1 pulled by alarm 2", pin1_pull_lo, 1'b1);
        al2_en = 0; step();
        expect_bit("R8 pin1 released when disabled", pin1_pull_lo, 1'b0);

        // R9: shared routing
        al2_en = 1; route_split = 0; step();
        expect_bit("R9 pin0 from alarm 2", pin0_pull_lo, 1'b1);

        // R7: match and clear together
        al2_clr = 1; sec_tick = 1; step(); al2_clr = 0; sec_tick = 0;
        expect_bit("R7 set beats clear", al2_flag, 1'b1);
        al2_clr = 1; step(); al2_clr = 0;

        // R10: cycles to the first low half of each rate
        for (int r = 0; r < 4; r++) begin
            int n;
            int want;
            sq_rate = 2'(r);
            want = (r == 3) ? 1 : (r == 2) ? 4 : (r == 1) ? 8 : 32768;
            half_tick = 0; route_split = 0;
            do_reset();
            half_tick = 1;
            n = 0;
            while (pin1_pull_lo !== 1'b1 && n < 40000) begin
                step();
                n++;
            end
            half_tick = 0;
            n_cmp++;
            if (n != want) begin
                n_bad++;
                $display("FAIL R10 rate %0d strobes to low actual=%0d expected=%0d", r, n, want);
            end
        end

        // random mix
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            if (i % 40 == 0) begin
                al1_sec  = pick(8'h00, 8'h15) | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                al1_min  = pick(8'h30, 8'h31) | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                al1_hour = pick(8'h08, 8'h48) | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                al1_day  = pick(8'h03, 8'h12) | (($urandom % 2) ? 8'h40 : 8'h00)
                           | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                al2_min  = pick(8'h30, 8'h31) | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                al2_hour = pick(8'h08, 8'h48) | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                al2_day  = pick(8'h03, 8'h12) | (($urandom % 2) ? 8'h40 : 8'h00)
                           | (($urandom % 4 == 0) ? 8'h80 : 8'h00);
                route_split = 1'($urandom % 2);
                al1_en = 1'($urandom % 2);
                al2_en = 1'($urandom % 2);
                sq_rate = 2'($urandom % 4);
            end
            set_time(pick(8'h00, 8'h15), pick(8'h30, 8'h31), pick(8'h08, 8'h48),
                     pick(8'h03, 8'h04), pick(8'h12, 8'h03));
            sec_tick  = ($urandom % 5) < 2;
            half_tick = 1'($urandom % 2);
            al1_clr   = ($urandom % 7) == 0;
            al2_clr   = ($urandom % 7) == 0;
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule